// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a clocked host and an external asynchronous byte-wide static RAM of 512K locations. The host issues one read or one write at a time over a request/ready handshake. The controller then drives the memory's active-low chip select, write strobe, output enable and 19-bit address. It also drives a byte data bus that it can release. Every pin is sequenced so that each analog timing minimum holds.

Each minimum time is a nanosecond parameter. It is rounded up to whole periods of the clock-period parameter. A write holds the strobe low long enough for the pulse width, the data setup and the address setup. A recovery phase then pads the access to the full cycle time. A read keeps select and output enable low until both the address access time and the enable access time have passed, and then captures the byte. After every read there is a float phase that covers the memory's output turn-off time, so a following write never meets a bus that is still driven. No access starts until a power-up wait has elapsed after reset. That wait is also a parameter, so a simulation can shorten it.

Top module: `sram_ctl`

## Requirements
- R1: During reset, and until at least the power-up count (BOOT_NS rounded up to clock cycles) has elapsed after reset is released, ready is 0, select, strobe and output enable are 1 (inactive), and the data bus is not driven.
- R2: A request is taken only when req and ready are both 1 at a clock edge, and ready is 0 in the cycle that follows. A req held while ready is 0 starts no memory access (select stays 1).
- R3: The write strobe is low only while select is low. Output enable stays high for the whole strobe. The strobe stays low for at least the rounded-up count of the largest of the pulse-width, address-to-end and data-setup minimums.
- R4: While the strobe is low, the address does not change. The data bus is driven with one unchanged byte for at least the data-setup count before the strobe rises.
- R5: From one falling edge of select that starts a write to the next falling edge of select, at least the write-cycle count of clocks passes.
- R6: A read holds select and output enable low and the strobe high. The byte is captured no earlier than the address-access count after select and the address settle, and no earlier than the enable-access count after output enable falls. rvalid is a one-cycle pulse with that byte on rdata.
- R7: After output enable rises, the controller does not drive the data bus for at least the float count of cycles.
- R8: The controller never drives the data bus in a cycle where select and output enable are both low.
- R9: All 19 address bits reach the memory. The lowest location (0x00000) and the highest location (0x7FFFF) hold independent bytes.
- R10: Every nanosecond minimum is rounded up, never down, to a whole number of clock periods. For example, a 42 ns strobe at a 5 ns clock gives 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request, taken when ready is 1 |
| we | input | 1 | 1 = write, 0 = read, sampled with req |
| addr | input | 19 | Byte address of the request |
| wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle and able to take a request |
| rvalid | output | 1 | One-cycle pulse, read byte on rdata |
| rdata | output | 8 | Captured read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Byte that the controller drives onto the data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Byte that the memory returns on the data bus |

## Verification
The bench builds the controller with a 5 ns clock period and a 300 ns power-up wait, which turns a 40000-cycle wait into 60 cycles, so the boot interlock and many accesses fit in one short run. It sets the strobe minimum to 42 ns, which is not a whole multiple of the clock period, so a truncating conversion would give a strobe one cycle short. The memory model returns a marker byte until both access windows have passed, so a capture even one cycle early shows up as wrong data. Back-to-back writes and write-after-read sequences test the cycle-time padding and the float gap.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_BOOT,
        PH_IDLE,
        PH_WR_STROBE,
        PH_WR_RECOVER,
        PH_RD_ACCESS,
        PH_RD_FLOAT
    } phase_e;

    // round a nanosecond minimum up to whole clock periods
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_boot_wait.sv
`timescale 1ns/1ps
module sram_boot_wait #(
    parameter int BOOT_CYC = 40000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int CW = $clog2(BOOT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } boot_t;

    boot_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (!b_q.done) begin
            b_d.cnt = b_q.cnt + CW'(1);
            if (b_q.cnt == CW'(BOOT_CYC - 1)) begin
                b_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign done_o = b_q.done;

    // R1
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.done |=> b_q.done);

    // R1
    boot_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.cnt < CW'(BOOT_CYC)) && !b_q.done |=> (b_q.cnt != '0));

endmodule

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R5
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

    // R5
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int CLK_NS     = 5,
    parameter int BOOT_NS    = 200000,
    parameter int WPULSE_NS  = 40,
    parameter int WCYCLE_NS  = 55,
    parameter int WSETUP_NS  = 25,
    parameter int WADDR_NS   = 40,
    parameter int RACC_NS    = 55,
    parameter int ROE_NS     = 25,
    parameter int RFLOAT_NS  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int BOOT_CYC = imax(ns_to_cyc(BOOT_NS, CLK_NS), 1);
    localparam int N_STB    = imax(imax(ns_to_cyc(WPULSE_NS, CLK_NS),
                                        ns_to_cyc(WADDR_NS, CLK_NS)),
                                   imax(ns_to_cyc(WSETUP_NS, CLK_NS), 1));
    localparam int N_WCYC   = imax(ns_to_cyc(WCYCLE_NS, CLK_NS), N_STB + 1);
    localparam int N_REC    = N_WCYC - N_STB;
    localparam int N_RD     = imax(imax(ns_to_cyc(RACC_NS, CLK_NS),
                                        ns_to_cyc(ROE_NS, CLK_NS)), 1);
    localparam int N_FLT    = imax(ns_to_cyc(RFLOAT_NS, CLK_NS), 1);
    localparam int N_MAX    = imax(imax(N_STB, N_REC), imax(N_RD, N_FLT));
    localparam int TW       = imax($clog2(N_MAX + 1), 1);

    typedef struct packed {
        phase_e        ph;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        logic          dq_oe;
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          ready;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        ph:     PH_BOOT,
        ce_n:   1'b1,
        we_n:   1'b1,
        oe_n:   1'b1,
        addr:   '0,
        dout:   '0,
        dq_oe:  1'b0,
        rdata:  '0,
        rvalid: 1'b0,
        ready:  1'b0
    };

    ctl_t          c_d, c_q;
    logic          boot_done;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;

    sram_boot_wait #(
        .BOOT_CYC (BOOT_CYC)
    ) u_boot (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (boot_done)
    );

    sram_phase_timer #(
        .TW (TW)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        c_d      = c_q;
        c_d.rvalid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (c_q.ph)
            PH_BOOT: begin
                if (boot_done) begin
                    c_d.ph    = PH_IDLE;
                    c_d.ready = 1'b1;
                end
            end
            PH_IDLE: begin
                if (req) begin
                    c_d.ready = 1'b0;
                    c_d.addr  = addr;
                    c_d.ce_n  = 1'b0;
                    tmr_load  = 1'b1;
                    if (we) begin
                        c_d.ph    = PH_WR_STROBE;
                        c_d.we_n  = 1'b0;
                        c_d.dout  = wdata;
                        c_d.dq_oe = 1'b1;
                        tmr_val   = TW'(N_STB - 1);
                    end else begin
                        c_d.ph    = PH_RD_ACCESS;
                        c_d.oe_n  = 1'b0;
                        tmr_val   = TW'(N_RD - 1);
                    end
                end
            end
            PH_WR_STROBE: begin
                if (tmr_expired) begin
                    c_d.ph   = PH_WR_RECOVER;
                    c_d.we_n = 1'b1;
                    c_d.ce_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_REC - 1);
                end
            end
            PH_WR_RECOVER: begin
                if (tmr_expired) begin
                    c_d.ph    = PH_IDLE;
                    c_d.dq_oe = 1'b0;
                    c_d.ready = 1'b1;
                end
            end
            PH_RD_ACCESS: begin
                if (tmr_expired) begin
                    c_d.ph     = PH_RD_FLOAT;
                    c_d.rdata  = mem_dq_in;
                    c_d.rvalid = 1'b1;
                    c_d.oe_n   = 1'b1;
                    c_d.ce_n   = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(N_FLT - 1);
                end
            end
            PH_RD_FLOAT: begin
                if (tmr_expired) begin
                    c_d.ph    = PH_IDLE;
                    c_d.ready = 1'b1;
                end
            end
            default: begin
                c_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CTL_RST;
        end else begin
            c_q <= c_d;
        end
    end

    assign ready      = c_q.ready;
    assign rvalid     = c_q.rvalid;
    assign rdata      = c_q.rdata;
    assign mem_ce_n   = c_q.ce_n;
    assign mem_we_n   = c_q.we_n;
    assign mem_oe_n   = c_q.oe_n;
    assign mem_addr   = c_q.addr;
    assign mem_dq_out = c_q.dout;
    assign mem_dq_oe  = c_q.dq_oe;

    // R1
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> (mem_ce_n && !ready));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

    // R2
    take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

    // R3
    strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // R4
    strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R6
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_oe_n) |-> !mem_dq_oe);

endmodule

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int CLK_NS = 5;
    localparam int BOOT_NS = 300;
    localparam int WPULSE_NS = 42;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // expected minimums, derived from the requirements
    localparam int E_BOOT = cdiv(BOOT_NS, CLK_NS);   // 60
    localparam int E_STB  = cdiv(WPULSE_NS, CLK_NS); // 9 (R10)
    localparam int E_DS   = cdiv(25, CLK_NS);        // 5
    localparam int E_WC   = cdiv(55, CLK_NS);        // 11
    localparam int E_AA   = cdiv(55, CLK_NS);        // 11
    localparam int E_OE   = cdiv(25, CLK_NS);        // 5
    localparam int E_HZ   = cdiv(20, CLK_NS);        // 4

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready, rvalid;
    logic [DW-1:0] rdata;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hA5;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_ctl #(
        .AW        (AW),
        .DW        (DW),
        .CLK_NS    (CLK_NS),
        .BOOT_NS   (BOOT_NS),
        .WPULSE_NS (WPULSE_NS)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .we         (we),
        .addr       (addr),
        .wdata      (wdata),
        .ready      (ready),
        .rvalid     (rvalid),
        .rdata      (rdata),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
        end
    endtask

    // ---------------- memory model and timing monitor ----------------
    logic [DW-1:0] store [int];
    int cyc = 0;
    int we_run = 0, ds_run = 0, acc_run = 0, oe_run = 0;
    int since_oe_rise = -1, last_wr_ce_fall = -1000;
    logic prev_we_n = 1'b1, prev_ce_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
    logic [AW-1:0] prev_addr = '0, wr_addr = '0;
    logic [DW-1:0] prev_dout = '0;

    always @(negedge clk) begin
        if (!rst_n || finished) begin
            prev_we_n = 1'b1; prev_ce_n = 1'b1; prev_oe_n = 1'b1; prev_dq_oe = 1'b0;
            we_run = 0; ds_run = 0; acc_run = 0; oe_run = 0;
        end else begin
            cyc++;
            // R8 bus contention
            check(!(!mem_ce_n && !mem_oe_n && mem_dq_oe), "R8 contention", mem_dq_oe, 0);
            // write strobe window
            if (!mem_we_n) begin
                check(!mem_ce_n && mem_oe_n, "R3 strobe w/o select or with oe", {mem_ce_n, mem_oe_n}, 2'b01);
                if (we_run == 0) begin
                    wr_addr = mem_addr;
                    ds_run = mem_dq_oe ? 1 : 0;
                end else begin
                    check(mem_addr == wr_addr, "R4 addr moved", mem_addr, wr_addr);
                    ds_run = (mem_dq_oe && mem_dq_out == prev_dout) ? ds_run + 1 : (mem_dq_oe ? 1 : 0);
                end
                we_run++;
            end else if (!prev_we_n) begin
                check(we_run >= E_STB, "R3/R10 strobe width", we_run, E_STB);
                check(ds_run >= E_DS, "R4 data setup", ds_run, E_DS);
                store[int'(wr_addr)] = prev_dout;
                we_run = 0;
            end
            // select falling edges after writes
            if (prev_ce_n && !mem_ce_n) begin
                if (last_wr_ce_fall >= 0 && (cyc - last_wr_ce_fall) < 1000)
                    check((cyc - last_wr_ce_fall) >= E_WC, "R5 write cycle", cyc - last_wr_ce_fall, E_WC);
                last_wr_ce_fall = !mem_we_n ? cyc : -1000;
            end
            // float window after oe rises
            if (!prev_oe_n && mem_oe_n) since_oe_rise = 1;
            else if (since_oe_rise > 0) since_oe_rise++;
            if (!prev_dq_oe && mem_dq_oe && since_oe_rise > 0) begin
                check(since_oe_rise > E_HZ, "R7 float gap", since_oe_rise - 1, E_HZ);
                since_oe_rise = -1;
            end
            // read access windows
            acc_run = (!mem_ce_n && !prev_ce_n && mem_addr == prev_addr) ? acc_run + 1 : (!mem_ce_n ? 1 : 0);
            oe_run  = (!mem_oe_n) ? oe_run + 1 : 0;
            if (!mem_ce_n && !mem_oe_n && mem_we_n && acc_run >= E_AA && oe_run >= E_OE)
                mem_dq_in = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
            else
                mem_dq_in = 8'hA5;
            prev_we_n = mem_we_n; prev_ce_n = mem_ce_n; prev_oe_n = mem_oe_n;
            prev_dq_oe = mem_dq_oe; prev_addr = mem_addr; prev_dout = mem_dq_out;
        end
    end

    // ---------------- host-side tasks ----------------
    logic [DW-1:0] shadow [int];

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wait_ready();
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        check(ready == 1'b0, "R2 ready drop", ready, 0);
        shadow[int'(a)] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        logic [DW-1:0] exp;
        exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
        wait_ready();
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        check(ready == 1'b0, "R2 ready drop", ready, 0);
        while (!rvalid) @(negedge clk);
        check(rdata == exp, "R6/R9 read data", rdata, exp);
        @(negedge clk);
        check(rvalid == 1'b0, "R6 rvalid pulse", rvalid, 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int boot_cyc;
        bit ce_seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!ready && !rvalid && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 reset state", {ready, rvalid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b001110);
        // R2: request held during boot must be ignored
        req = 1'b1; we = 1'b1; addr = 19'h00055; wdata = 8'h11;
        rst_n = 1'b1;
        boot_cyc = 0;
        ce_seen = 0;
        while (!ready && boot_cyc < 5000) begin
            @(negedge clk);
            if (!ready) boot_cyc++;
            if (!mem_ce_n && !ready) ce_seen = 1;
        end
        req = 1'b0;
        check(!ce_seen, "R2 req ignored while not ready", ce_seen, 0);
        check(boot_cyc >= E_BOOT, "R1 boot wait", boot_cyc, E_BOOT);
        @(negedge clk);
        check(mem_ce_n, "R2 held req not queued", mem_ce_n, 1);

        // R9 extreme addresses
        do_write(19'h00000, 8'h3C);
        do_write(19'h7FFFF, 8'hC3);
        do_read(19'h00000);
        do_read(19'h7FFFF);
        // write after read turnaround, then overwrite
        do_write(19'h12345, 8'h5A);
        do_read(19'h12345);
        do_write(19'h12345, 8'h81);
        do_read(19'h12345);
        // single-bit addresses
        for (int b = 0; b < AW; b++) begin
            do_write(19'(1 << b), 8'(b * 13 + 2));
        end
        for (int b = 0; b < AW; b++) begin
            do_read(19'(1 << b));
        end
        // mixed pattern
        for (int i = 0; i < 24; i++) begin
            logic [DW-1:0] d;
            d = 8'(i * 37 + 1);
            if (d == 8'hA5) d = 8'h5B;
            if (i % 3 == 2) do_read(19'(i * 4099));
            else do_write(19'(i * 4099), d);
        end
        for (int i = 0; i < 24; i++) do_read(19'(i * 4099));
        // unwritten location reads as model default
        do_read(19'h2AAAA);

        repeat (10) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule